// File: doc/BRIEF.md
# Segmented DAC Code Controller

This block turns one channel's latched 16-bit two's-complement audio sample into the switch controls of a three-segment converter. The sample is first shifted to offset binary by flipping its sign bit, then cut into three fields. The top nine bits pick a tap pair on a 512-division resistor string. The next three bits set a duty count that, over an eight-clock period, chooses the upper of the two adjacent taps for that many clocks and the lower tap for the rest. The bottom four bits set a pair of trim codes for the resistors at the ends of the string; the two codes always add up to fifteen.

A sample arrives with a one-cycle valid strobe and is held as pending until the next PWM period begins. Only then do all three fields change together, so no period is ever cut short or mixed between two samples. When several strobes arrive inside one period, the most recent wins. The clock is the PWM clock chosen by the system (a dedicated system clock or the bit clock); the analog network itself lies outside the block.

Top module: `segdac_ctrl`

## Requirements
- R1: After reset the outputs show mid-scale: tap index 256, tap select low, lower trim 0, upper trim 15.
- R2: The tap index equals bits 15..7 of the applied sample after bit 15 is inverted (sample 0x8000 gives tap 0, 0x7FFF gives tap 511).
- R3: The PWM period is 8 clocks; in the clocks numbered 0..7 of a period the tap select is high exactly in clocks 0..N-1, where N is bits 6..4 of the applied sample, so N=0 keeps it low the whole period.
- R4: The lower trim code equals bits 3..0 of the applied sample and the upper trim code equals 15 minus that value, so their sum is always 15.
- R5: A strobed sample changes no output before the next period start; all outputs change only on the clock edge that begins a period.
- R6: A strobe on the last clock of a period is applied at the period start that follows immediately.
- R7: When several strobes arrive within one period, only the last one is applied.
- R8: With no new strobe, the applied sample repeats every period unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | One-cycle strobe marking a new sample |
| smp_word | input | 16 | Two's-complement sample, MSB is bit 15 |
| tap_idx | output | 9 | Lower tap of the selected resistor-string pair |
| tap_hi | output | 1 | 1 selects the upper tap, 0 the lower tap |
| trim_up | output | 4 | Upper end trim code |
| trim_dn | output | 4 | Lower end trim code |

## Verification
The period boundary that applies a held sample and a fresh strobe can land on the same clock edge; in that case the fresh word must be the one applied, not the older pending word. The bench provokes this by strobing on clock 7 of a period, and separately by strobing twice within one period, and judges both by reading tap index, trim codes and the whole next period of tap select against values it derives from the sample with its own arithmetic. Strobes placed mid-period are also checked to leave every output untouched until the boundary.

// File: rtl/segdac_pkg.sv
package segdac_pkg;

  localparam int SMP_W  = 16;
  localparam int TAP_W  = 9;
  localparam int DUTY_W = 3;
  localparam int TRIM_W = SMP_W - TAP_W - DUTY_W;

  // two's complement to offset binary
  function automatic logic [SMP_W-1:0] to_offset(input logic [SMP_W-1:0] w);
    to_offset = {~w[SMP_W-1], w[SMP_W-2:0]};
  endfunction

  function automatic logic [TAP_W-1:0] tap_of(input logic [SMP_W-1:0] w);
    logic [SMP_W-1:0] ob;
    ob = to_offset(w);
    tap_of = ob[SMP_W-1 -: TAP_W];
  endfunction

  function automatic logic [DUTY_W-1:0] duty_of(input logic [SMP_W-1:0] w);
    duty_of = w[TRIM_W +: DUTY_W];
  endfunction

  function automatic logic [TRIM_W-1:0] trim_lo_of(input logic [SMP_W-1:0] w);
    trim_lo_of = w[TRIM_W-1:0];
  endfunction

  // all-ones minus the low code: the complement keeps the pair sum fixed
  function automatic logic [TRIM_W-1:0] trim_hi_of(input logic [SMP_W-1:0] w);
    trim_hi_of = ~w[TRIM_W-1:0];
  endfunction

endpackage

// File: rtl/segdac_pwm.sv
module segdac_pwm #(
  parameter int DUTY_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] duty,
  output logic [DUTY_W-1:0] cnt,
  output logic              per_end,
  output logic              hi
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign per_end = &cnt;
  assign hi      = (cnt < duty);

endmodule

// File: rtl/segdac_hold.sv
module segdac_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_vld,
  input  logic [W-1:0] smp_word,
  input  logic         take,
  output logic         pend_vld,
  output logic         next_ok,
  output logic [W-1:0] next_word
);

  logic [W-1:0] pend_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_word <= '0;
    end else begin
      if (smp_vld) pend_word <= smp_word;
      if (take)         pend_vld <= 1'b0;
      else if (smp_vld) pend_vld <= 1'b1;
    end
  end

  // a strobe in the same cycle overrides the held word
  assign next_ok   = smp_vld | pend_vld;
  assign next_word = smp_vld ? smp_word : pend_word;

endmodule

// File: rtl/segdac_ctrl.sv
module segdac_ctrl
  import segdac_pkg::*;
#(
  parameter int WORD_W = segdac_pkg::SMP_W,
  parameter int IDX_W  = segdac_pkg::TAP_W,
  parameter int PWM_W  = segdac_pkg::DUTY_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           smp_vld,
  input  logic [WORD_W-1:0]              smp_word,
  output logic [IDX_W-1:0]               tap_idx,
  output logic                           tap_hi,
  output logic [WORD_W-IDX_W-PWM_W-1:0]  trim_up,
  output logic [WORD_W-IDX_W-PWM_W-1:0]  trim_dn
);

  localparam int LSB_W = WORD_W - IDX_W - PWM_W;

  logic              pend_vld;
  logic              next_ok;
  logic [WORD_W-1:0] next_word;
  logic [WORD_W-1:0] act_word;
  logic [PWM_W-1:0]  pwm_cnt;
  logic              per_end;
  logic              load;

  segdac_hold #(.W(WORD_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (smp_vld),
    .smp_word  (smp_word),
    .take      (per_end),
    .pend_vld  (pend_vld),
    .next_ok   (next_ok),
    .next_word (next_word)
  );

  assign load = per_end & next_ok;

  // applied sample, two's complement zero is mid-scale
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act_word <= '0;
    else if (load) act_word <= next_word;
  end

  segdac_pwm #(.DUTY_W(PWM_W)) u_pwm (
    .clk     (clk),
    .rst_n   (rst_n),
    .duty    (duty_of(act_word)),
    .cnt     (pwm_cnt),
    .per_end (per_end),
    .hi      (tap_hi)
  );

  assign tap_idx = tap_of(act_word);
  assign trim_dn = trim_lo_of(act_word);
  assign trim_up = trim_hi_of(act_word);

endmodule

// File: rtl/segdac_ctrl_chk.sv
module segdac_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        smp_vld,
  input logic [15:0] smp_word,
  input logic [8:0]  tap_idx,
  input logic        tap_hi,
  input logic [3:0]  trim_up,
  input logic [3:0]  trim_dn,
  input logic [2:0]  pwm_cnt,
  input logic        per_end,
  input logic        pend_vld
);

  p_trim_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, trim_up} + {1'b0, trim_dn}) == 5'd15);

  p_change_at_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_idx != $past(tap_idx) || trim_dn != $past(trim_dn)) |-> $past(per_end));

  p_hi_from_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_hi && pwm_cnt != 3'd0) |-> $past(tap_hi));

  p_hi_low_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_cnt == 3'd7 && tap_hi) |-> $stable(tap_idx));

  p_coincide_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (per_end && smp_vld) |=> (tap_idx == {~$past(smp_word[15]), $past(smp_word[14:7])}));

  p_pend_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    per_end |=> !pend_vld);

endmodule

bind segdac_ctrl segdac_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smp_vld  (smp_vld),
  .smp_word (smp_word),
  .tap_idx  (tap_idx),
  .tap_hi   (tap_hi),
  .trim_up  (trim_up),
  .trim_dn  (trim_dn),
  .pwm_cnt  (pwm_cnt),
  .per_end  (per_end),
  .pend_vld (pend_vld)
);

// File: tb/tb_segdac_ctrl.sv
module tb_segdac_ctrl;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_vld = 1'b0;
  logic [15:0] smp_word = '0;
  logic [8:0]  tap_idx;
  logic        tap_hi;
  logic [3:0]  trim_up, trim_dn;

  int n_chk = 0;
  int n_bad = 0;
  int ph = 0;
  logic [15:0] cur = 16'h0000;

  always #(CLK_P/2) clk = ~clk;

  segdac_ctrl dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_word(smp_word),
    .tap_idx(tap_idx), .tap_hi(tap_hi), .trim_up(trim_up), .trim_dn(trim_dn)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int e_tap(input logic [15:0] w);
    e_tap = ((int'(w) + 32768) % 65536) / 128;
  endfunction
  function automatic int e_n(input logic [15:0] w);  e_n  = (int'(w) / 16) % 8; endfunction
  function automatic int e_dn(input logic [15:0] w); e_dn = int'(w) % 16;       endfunction

  task automatic tick();
    @(negedge clk);
    ph = (ph + 1) % 8;
  endtask

  task automatic wait_ph(input int p);
    while (ph != p) tick();
  endtask

  task automatic chk_static(input string req, input logic [15:0] w);
    chk({req, " tap"}, tap_idx, e_tap(w));
    chk({req, " trim_dn"}, trim_dn, e_dn(w));
    chk({req, " trim_up"}, trim_up, 15 - e_dn(w));
  endtask

  // one full period starting at ph 0
  task automatic chk_period(input string req, input logic [15:0] w);
    chk_static(req, w);
    for (int i = 0; i < 8; i++) begin
      chk({req, " R3 tap_hi"}, tap_hi, (i < e_n(w)) ? 1 : 0);
      tick();
    end
  endtask

  task automatic strobe(input logic [15:0] w);
    smp_vld = 1'b1; smp_word = w;
    tick();
    smp_vld = 1'b0; smp_word = 16'hDEAD;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 tap", tap_idx, 256);
    chk("R1 hi", tap_hi, 0);
    chk("R1 dn", trim_dn, 0);
    chk("R1 up", trim_up, 15);
    rst_n = 1'b1; ph = 0; cur = 16'h0000;
    chk_period("R1", cur);
  endtask

  // strobe at phase p, outputs hold until boundary, then new period checked
  task automatic t_apply(input logic [15:0] w, input int p);
    wait_ph(p);
    strobe(w);
    while (ph != 0) begin
      chk_static("R5 hold", cur);
      tick();
    end
    cur = w;
    chk_period((p == 7) ? "R6 R2 R4" : "R2 R4", w);
  endtask

  task automatic t_last_wins(input logic [15:0] a, input logic [15:0] b);
    wait_ph(1); strobe(a);
    wait_ph(4); strobe(b);
    wait_ph(0);
    cur = b;
    chk_period("R7", b);
  endtask

  task automatic t_hold();
    chk_period("R8 first", cur);
    chk_period("R8 second", cur);
  endtask

  initial begin
    t_reset();
    t_apply(16'h8000, 2);
    t_apply(16'h7FFF, 3);
    t_apply(16'h0000, 5);
    t_apply(16'hFFFF, 1);
    t_apply(16'h1234, 6);
    t_apply(16'hA5C3, 7);
    t_apply(16'h4B70, 7);
    t_last_wins(16'h0F0F, 16'hC350);
    t_hold();
    t_apply(16'h0008, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule